// File: doc/BRIEF.md
# Signal Unit Error Rate Monitor (interval-sampled variant)

This block watches the error rate of a signalling link with a leaky bucket. The receive path raises `err_i` for one cycle each time it detects a faulty signal unit. A clock prescaler divides time into fixed sampling intervals, and a sticky flag gathers every error strobe that arrives within an interval. When the interval ends, a saturating counter moves. It rises by a large step if the interval held any error. It falls by one if the interval was clean, and it never goes below zero.

When an errored interval takes the counter to the threshold or past it, the block does two things in the same cycle. It clears the counter and it raises a one-cycle interrupt. The link layer uses this interrupt to take the link out of service.

Interval-based counting runs only when the variant-select input is 1 and the disable input is 0. In every other case the counter, the sticky flag and the prescaler are held at zero and no interrupt is raised. The defaults are a step of 16, a threshold of 285, and an interval of 4,800,000 clocks, which is 24 ms at 200 MHz. All three are parameters.

Top module: `suerm_monitor`

## Requirements
- R1: After reset, `count_o` is 0 and `irq_o` is 0, and `count_o` never holds a value at or above THRESH.
- R2: While enabled, an interval ends every TICK_DIV clocks, counted from the cycle the block became enabled. `count_o` changes only in the cycle after an interval end.
- R3: At the end of an interval that saw an error, `count_o` increases by STEP (16), provided the result stays below THRESH.
- R4: At the end of an interval that saw no error, `count_o` decreases by 1. It stays at 0 if it is already 0.
- R5: Any number of `err_i` strobes within one interval cause a single increment. A strobe in the clock cycle that ends the interval counts toward that interval.
- R6: When an errored interval would take the counter to THRESH (285) or above, `count_o` becomes 0 and `irq_o` is 1 for exactly that one cycle. `irq_o` is never high in two consecutive cycles.
- R7: While `dis_i` is 1, `count_o` is 0 from the next cycle on and `irq_o` stays 0. Error strobes have no effect, and the interval timing restarts when the block is enabled again.
- R8: While `std_jp_i` is 0, the block behaves as under R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | One-cycle strobe for each errored signal unit |
| dis_i | input | 1 | 1 turns the monitor off |
| std_jp_i | input | 1 | 1 selects interval-based counting; 0 keeps the monitor idle |
| irq_o | output | 1 | One-cycle pulse when the threshold is reached |
| count_o | output | CNT_W | Current counter value |

## Verification
The counter is visible at all times, so a wrong internal state usually shows on `count_o` in the cycle after the interval end where it arises. A sticky flag that was not cleared shows up as a false +16 one interval later. A prescaler that is off by one shifts every counter change by a clock, and a cycle-accurate model catches that at the first tick. A wrong compare against the threshold shows up either as a missing clear and interrupt, or as a counter value of 285 or more. Either case appears within the eighteen errored intervals that are needed to fire from zero.

// File: rtl/suerm_pkg.sv
package suerm_pkg;
  localparam int unsigned DEF_THRESH   = 285;
  localparam int unsigned DEF_STEP     = 16;
  localparam int unsigned DEF_TICK_DIV = 4_800_000; // 24 ms at 200 MHz

  function automatic int unsigned cnt_width(input int unsigned thresh);
    return (thresh > 1) ? $clog2(thresh) : 1;
  endfunction
endpackage

// File: rtl/suerm_prescaler.sv
module suerm_prescaler #(
  parameter int unsigned TICK_DIV = suerm_pkg::DEF_TICK_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = en_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] cnt_q;

      assign tick_o = en_i && (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (!en_i)  cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/suerm_err_latch.sv
module suerm_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic err_i,
  output logic seen_o
);
  logic flag_q;

  // strobe in the tick cycle belongs to the closing interval
  assign seen_o = flag_q | err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flag_q <= 1'b0;
    else if (!en_i || tick_i) flag_q <= 1'b0;
    else if (err_i)          flag_q <= 1'b1;
  end
endmodule

// File: rtl/suerm_bucket.sv
module suerm_bucket #(
  parameter int unsigned THRESH = suerm_pkg::DEF_THRESH,
  parameter int unsigned STEP   = suerm_pkg::DEF_STEP,
  parameter int unsigned CNT_W  = suerm_pkg::cnt_width(THRESH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             seen_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam int unsigned SW = $clog2(THRESH + STEP + 1) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic [SW-1:0]    up;

  assign up = SW'(cnt_q) + SW'(STEP);

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (seen_i) begin
        if (up >= SW'(THRESH)) begin
          cnt_d = '0;
          irq_d = 1'b1;
        end else begin
          cnt_d = up[CNT_W-1:0];
        end
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/suerm_monitor.sv
module suerm_monitor #(
  parameter int unsigned THRESH   = suerm_pkg::DEF_THRESH,
  parameter int unsigned STEP     = suerm_pkg::DEF_STEP,
  parameter int unsigned TICK_DIV = suerm_pkg::DEF_TICK_DIV,
  parameter int unsigned CNT_W    = suerm_pkg::cnt_width(THRESH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             dis_i,
  input  logic             std_jp_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  logic en, tick, seen;

  assign en = std_jp_i & ~dis_i;

  suerm_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .tick_o(tick)
  );

  suerm_err_latch u_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .tick_i(tick),
    .err_i (err_i),
    .seen_o(seen)
  );

  suerm_bucket #(.THRESH(THRESH), .STEP(STEP), .CNT_W(CNT_W)) u_bkt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .tick_i(tick),
    .seen_i(seen),
    .cnt_o (count_o),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/suerm_monitor_chk.sv
module suerm_monitor_chk #(
  parameter int unsigned THRESH = suerm_pkg::DEF_THRESH,
  parameter int unsigned STEP   = suerm_pkg::DEF_STEP,
  parameter int unsigned CNT_W  = suerm_pkg::cnt_width(THRESH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dis_i,
  input logic             std_jp_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_o
);
  logic en;
  assign en = std_jp_i & ~dis_i;

  // R1
  cnt_below_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_o) < THRESH);

  // R6
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R6
  irq_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> count_o == '0);

  // R7 R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (count_o == '0 && !irq_o));

  // R3 R4
  step_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en) && !irq_o && count_o != $past(count_o)) |->
      (32'(count_o) == 32'($past(count_o)) + STEP ||
       32'(count_o) + 1 == 32'($past(count_o))));
endmodule

bind suerm_monitor suerm_monitor_chk #(.THRESH(THRESH), .STEP(STEP), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dis_i   (dis_i),
  .std_jp_i(std_jp_i),
  .irq_o   (irq_o),
  .count_o (count_o)
);

// File: tb/tb_suerm_monitor.sv
module tb_suerm_monitor;
  localparam int unsigned THRESH = 285;
  localparam int unsigned STEP   = 16;
  localparam int unsigned DIV    = 4;
  localparam int unsigned CW     = suerm_pkg::cnt_width(THRESH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic err = 1'b0, dis = 1'b0, stdj = 1'b1;
  logic irq;
  logic [CW-1:0] cnt;

  int n_chk = 0, n_err = 0, n_irq = 0;
  bit done = 0;

  // reference state
  int m_pc = 0, m_cnt = 0, m_ec = 0;
  bit m_flag = 0, m_irq = 0;
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  suerm_monitor #(.THRESH(THRESH), .STEP(STEP), .TICK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .dis_i(dis),
    .std_jp_i(stdj), .irq_o(irq), .count_o(cnt)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: one clock edge with the applied inputs
  function automatic void model(bit e, bit d, bit s);
    bit en, tick, seen;
    int up;
    en = s && !d;
    m_irq = 0;
    if (!en) begin
      m_pc = 0; m_flag = 0; m_cnt = 0; m_ec = 0;
      m_tag = d ? "R7" : "R8";
      return;
    end
    tick = (m_pc == DIV - 1);
    seen = m_flag || e;
    m_ec += e ? 1 : 0;
    if (tick) begin
      m_pc = 0; m_flag = 0;
      if (seen) begin
        up = m_cnt + STEP;
        if (up >= THRESH) begin m_cnt = 0; m_irq = 1; m_tag = "R6"; end
        else begin m_cnt = up; m_tag = (m_ec > 1) ? "R5" : "R3"; end
      end else begin
        if (m_cnt > 0) m_cnt--;
        m_tag = "R4";
      end
      m_ec = 0;
    end else begin
      m_pc++; m_flag = seen; m_tag = "R2";
    end
  endfunction

  task automatic cyc(bit e, bit d, bit s);
    err = e; dis = d; stdj = s;
    @(posedge clk);
    model(e, d, s);
    @(negedge clk);
    check(m_tag, int'(cnt), m_cnt);
    check(m_tag, int'(irq), int'(m_irq));
    if (irq) n_irq++;
  endtask

  task automatic interval(bit with_err, int nerr);
    for (int i = 0; i < int'(DIV); i++)
      cyc(with_err && (i >= int'(DIV) - nerr), 1'b0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", int'(cnt), 0);
        check("R1", int'(irq), 0);
        rst_n = 1'b1;
        // R3 single errored interval
        interval(1, 1);
        check("R3", int'(cnt), STEP);
        // R4 clean interval then floor
        interval(0, 0);
        check("R4", int'(cnt), STEP - 1);
        for (int i = 0; i < 20; i++) interval(0, 0);
        check("R4", int'(cnt), 0);
        // R5 several strobes, incl. tick cycle, one increment
        interval(1, int'(DIV));
        check("R5", int'(cnt), STEP);
        // R6 drive to threshold
        for (int i = 0; i < 17; i++) interval(1, 1);
        check("R6", n_irq, 1);
        check("R6", int'(cnt), 0);
        // R7 disable mid-count, errors ignored
        interval(1, 1);
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b1);
        check("R7", int'(cnt), 0);
        // R8 other standard selected
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0);
        check("R8", int'(cnt), 0);
        // random phase
        for (int i = 0; i < 6000; i++) begin
          int pe;
          pe = (i / 1500) % 2 == 0 ? 70 : 20;
          cyc(($urandom % 100) < pe, ($urandom % 200) == 0, ($urandom % 250) != 0);
        end
        check("R6", int'(n_irq > 1), 1);
        done = 1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog: actual=timeout expected=finish");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule